// File: doc/BRIEF.md
# SD Card Clock Divider and Gate

This block derives the card clock of an SD/eMMC host from the fast source clock. A single 32-bit control word is written over a simple register bus. It selects a power-of-two division ratio between 1 and 1024, turns the card clock on or off, and can put the clock under control of the host's transfer engine. In that last mode the card clock runs only while a bus transfer is in progress.

The ratio comes from a one-hot field in bits [7:0]. If the field is zero, the ratio is 2. Two override bits pick pass-through (ratio 1) or ratio 1024. Both gating and ratio changes take effect only at phase boundaries of the divided clock, so the card never sees a shortened high or low phase. Software may still follow the usual practice of stopping the clock around a ratio change, but the block does not depend on it.

Top module: `sdclk_gen`

## Requirements
- R1: With the enable bit (bit 8) set and exactly one bit k of the field [7:0] set, the card clock has period 2^(k+2) source cycles, with high and low phases of equal length.
- R2: With the enable bit set, field [7:0] all zero and neither override bit set, the card clock is the source clock divided by 2.
- R3: With the enable bit set and bit 10 set, the card clock equals the source clock, whatever the field and bit 16 hold.
- R4: With the enable bit set, bit 16 set and bit 10 clear, the card clock is divided by 1024, whatever field [7:0] holds.
- R5: When several bits of field [7:0] are set, the highest set bit alone fixes the ratio.
- R6: With the enable bit clear, the card clock stays low. This holds in the divided modes and in pass-through.
- R7: With the auto-stop bit (bit 9) set, the card clock stays low while bus_busy is low, even with the enable bit set. It runs at the programmed ratio while bus_busy is high.
- R8: A high phase that has started always lasts its full N/2 source cycles. This holds when the enable bit is cleared or bus_busy falls part-way through it, and the clock then stays low.
- R9: A ratio written while the clock runs takes effect from the start of the next low phase. No phase shorter than the smaller of the old and new half-periods appears.
- R10: After reset the control word reads zero and the card clock is low.
- R11: reg_rdata returns the written value of bits [10:0] and bit 16. Every other bit reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_we | input | 1 | Write strobe for the control word |
| reg_wdata | input | 32 | Control word write data |
| reg_rdata | output | 32 | Control word read-back |
| bus_busy | input | 1 | High while the host runs a bus transfer (used by auto-stop) |
| card_clk | output | 1 | Divided and gated card clock |

## Verification
A stop request can land in the same source cycle in which the divided clock's high phase reaches its terminal count. The stop request is either a control write that clears the enable bit or a fall of bus_busy under auto-stop. The bench places the write at every offset within a divide-by-8 high phase, including the terminal one. Each time it requires a high phase of exactly four cycles followed by a silent clock. A ratio change that arrives while the clock runs is judged the same way: every observed phase must have either the old or the new width.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;
  localparam int REG_W       = 32;
  localparam int BIT_EN      = 8;   // clock enable
  localparam int BIT_AUTO    = 9;   // stop clock when bus idle
  localparam int BIT_DIV1    = 10;  // pass-through override
  localparam int BIT_DIV1024 = 16;  // extended ratio override
endpackage

// File: rtl/sdclk_div_decode.sv
// Maps the control bits to a ratio exponent: ratio = 2**exp, exp 0 = pass-through.
module sdclk_div_decode #(
  parameter int FIELD_W = 8,
  parameter int EXP_W   = 4
) (
  input  logic [FIELD_W-1:0] field,
  input  logic               sel_div1,
  input  logic               sel_max,
  output logic [EXP_W-1:0]   exp_o
);
  always_comb begin
    exp_o = EXP_W'(1);
    // ascending scan: the highest set bit overwrites lower ones
    for (int k = 0; k < FIELD_W; k++) begin
      if (field[k]) exp_o = EXP_W'(k + 2);
    end
    if (sel_max)  exp_o = EXP_W'(FIELD_W + 2);
    if (sel_div1) exp_o = '0;
  end
endmodule

// File: rtl/sdclk_phase_ctr.sv
// Half-period counter and phase register for ratios 2 and up.
module sdclk_phase_ctr #(
  parameter int EXP_W = 4,
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk_on,
  input  logic [EXP_W-1:0] new_exp,
  output logic             phase_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic [EXP_W-1:0] act_exp_q,
  output logic [CNT_W-1:0] half_m1
);
  logic [CNT_W:0]   span;
  logic             is_div1;
  logic             term;
  logic             phase_d;
  logic [CNT_W-1:0] cnt_d;
  logic [EXP_W-1:0] exp_d;

  assign is_div1 = (act_exp_q == '0);

  always_comb begin
    span    = '0;
    half_m1 = '0;
    if (!is_div1) begin
      span    = (CNT_W+1)'(1) << (act_exp_q - EXP_W'(1));
      half_m1 = CNT_W'(span - (CNT_W+1)'(1));
    end
  end

  assign term = (cnt_q == half_m1);

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    exp_d   = act_exp_q;
    if (!phase_q) begin
      if (!clk_on || is_div1) begin
        // idle or pass-through: accept a new ratio at once
        cnt_d = '0;
        exp_d = new_exp;
      end else if (term) begin
        phase_d = 1'b1;
        cnt_d   = '0;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end else begin
      if (term) begin
        // end of a full high phase: low phase starts with the latest ratio
        phase_d = 1'b0;
        cnt_d   = '0;
        exp_d   = new_exp;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= 1'b0;
      cnt_q     <= '0;
      act_exp_q <= EXP_W'(1);
    end else begin
      phase_q   <= phase_d;
      cnt_q     <= cnt_d;
      act_exp_q <= exp_d;
    end
  end
endmodule

// File: rtl/sdclk_out_gate.sv
// Output stage: pass-through path gated by a falling-edge enable, OR-ed with the divided phase.
module sdclk_out_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic run_div1,
  input  logic phase,
  output logic card_clk
);
  logic pass_q;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) pass_q <= 1'b0;
    else        pass_q <= run_div1;
  end

  assign card_clk = (clk & pass_q) | phase;
endmodule

// File: rtl/sdclk_gen.sv
module sdclk_gen
  import sdclk_pkg::*;
#(
  parameter int FIELD_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             bus_busy,
  output logic             card_clk
);
  localparam int MAX_EXP = FIELD_W + 2;
  localparam int EXP_W   = $clog2(MAX_EXP + 1);
  localparam int CNT_W   = MAX_EXP - 1;
  localparam logic [REG_W-1:0] REG_MASK =
      ((REG_W'(1) << FIELD_W) - REG_W'(1)) | (REG_W'(1) << BIT_EN) |
      (REG_W'(1) << BIT_AUTO) | (REG_W'(1) << BIT_DIV1) | (REG_W'(1) << BIT_DIV1024);

  logic             rst_meta, rst_i;
  logic [REG_W-1:0] ctrl_q, ctrl_d;
  logic             clk_on;
  logic [EXP_W-1:0] new_exp;
  logic             phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic [EXP_W-1:0] act_exp;
  logic [CNT_W-1:0] half_m1;
  logic             run_div1;

  // reset: asserted asynchronously, released after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_i    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_i    <= rst_meta;
    end
  end

  always_comb begin
    ctrl_d = ctrl_q;
    if (reg_we) ctrl_d = reg_wdata & REG_MASK;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  assign reg_rdata = ctrl_q;
  assign clk_on    = ctrl_q[BIT_EN] & (~ctrl_q[BIT_AUTO] | bus_busy);
  assign run_div1  = clk_on & (act_exp == '0);

  sdclk_div_decode #(.FIELD_W(FIELD_W), .EXP_W(EXP_W)) u_dec (
    .field    (ctrl_q[FIELD_W-1:0]),
    .sel_div1 (ctrl_q[BIT_DIV1]),
    .sel_max  (ctrl_q[BIT_DIV1024]),
    .exp_o    (new_exp)
  );

  sdclk_phase_ctr #(.EXP_W(EXP_W), .CNT_W(CNT_W)) u_ctr (
    .clk       (clk),
    .rst_n     (rst_i),
    .clk_on    (clk_on),
    .new_exp   (new_exp),
    .phase_q   (phase_q),
    .cnt_q     (cnt_q),
    .act_exp_q (act_exp),
    .half_m1   (half_m1)
  );

  sdclk_out_gate u_gate (
    .clk      (clk),
    .rst_n    (rst_i),
    .run_div1 (run_div1),
    .phase    (phase_q),
    .card_clk (card_clk)
  );
endmodule

// File: rtl/sdclk_gen_chk.sv
module sdclk_gen_chk #(
  parameter int          EXP_W = 4,
  parameter int          CNT_W = 9,
  parameter logic [31:0] MASK  = 32'h0001_07FF
) (
  input logic             clk,
  input logic             rst_n,
  input logic             phase,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] half_m1,
  input logic [EXP_W-1:0] act_exp,
  input logic             clk_on,
  input logic [31:0]      rdata
);
  // R11
  rdata_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata & ~MASK) == 32'h0);

  // R1
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= half_m1);

  // R8
  high_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase && (cnt != half_m1)) |=> phase);

  // R6
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!phase && !clk_on) |=> !phase);

  // R3
  div1_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_exp == '0) |-> !phase);

  // R9
  ratio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase && $past(phase)) |-> $stable(act_exp));
endmodule

bind sdclk_gen sdclk_gen_chk #(.EXP_W(EXP_W), .CNT_W(CNT_W), .MASK(REG_MASK)) u_chk (
  .clk     (clk),
  .rst_n   (rst_i),
  .phase   (phase_q),
  .cnt     (cnt_q),
  .half_m1 (half_m1),
  .act_exp (act_exp),
  .clk_on  (clk_on),
  .rdata   (reg_rdata)
);

// File: tb/sdclk_gen_test.sv
`timescale 1ns/1ps
module sdclk_gen_test;
  localparam logic [31:0] EN   = 32'h0000_0100;
  localparam logic [31:0] AUTO = 32'h0000_0200;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic        bus_busy = 1'b0;
  logic [31:0] reg_rdata;
  logic        card_clk;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  longint t_rise = 0, t_fall = 0;
  int hi_len = 0, lo_len = 0, rise_cnt = 0, fall_cnt = 0, min_run = 9999;
  logic smp_prev = 1'b0;

  always #5 clk = ~clk;

  sdclk_gen uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .bus_busy(bus_busy), .card_clk(card_clk)
  );

  // phase-length monitor, sampled 1 ns after each rising source edge
  always @(posedge clk) begin
    #1;
    if (card_clk === 1'b1 && smp_prev === 1'b0) begin
      rise_cnt++;
      lo_len = int'(($time - t_fall) / 10);
      if (lo_len < min_run) min_run = lo_len;
      t_rise = $time;
    end
    if (card_clk === 1'b0 && smp_prev === 1'b1) begin
      fall_cnt++;
      hi_len = int'(($time - t_rise) / 10);
      if (hi_len < min_run) min_run = hi_len;
      t_fall = $time;
    end
    smp_prev = card_clk;
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] v);
    @(negedge clk); reg_we = 1'b1; reg_wdata = v;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic wait_rises(input int n);
    int r0 = rise_cnt;
    int g = 0;
    while (rise_cnt < r0 + n && g < 6000) begin @(posedge clk); #2; g++; end
  endtask

  task automatic wait_fall(input int f0);
    int g = 0;
    while (fall_cnt <= f0 && g < 6000) begin @(posedge clk); #2; g++; end
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int r0, f0, err;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(3);
    // R10 reset state
    chk(reg_rdata == 32'h0, "R10", reg_rdata, 0);
    idle(20);
    chk(rise_cnt == 0 && card_clk == 1'b0, "R10", rise_cnt, 0);

    // R1 / R2 / R4 sweep over every ratio from 2 to 1024
    for (int e = 1; e <= 10; e++) begin
      logic [31:0] code;
      string tag;
      code = (e == 1) ? 32'h0 : ((e == 10) ? 32'h0001_0000 : (32'h1 << (e - 2)));
      tag  = (e == 1) ? "R2" : ((e == 10) ? "R4" : "R1");
      wr(code);
      wr(code | EN);
      wait_rises(2);
      chk(hi_len == (1 << (e - 1)), tag, hi_len, 1 << (e - 1));
      chk(lo_len == (1 << (e - 1)), tag, lo_len, 1 << (e - 1));
      wr(32'h0);
      idle(520);
    end

    // R5 highest field bit wins: bits 0 and 2 -> ratio 16
    wr(32'h05); wr(32'h05 | EN);
    wait_rises(2);
    chk(hi_len == 8 && lo_len == 8, "R5", hi_len, 8);
    wr(32'h0); idle(20);

    // R4 bit 16 overrides field bits
    wr(32'h0001_0004); wr(32'h0001_0004 | EN);
    wait_rises(2);
    chk(hi_len == 512 && lo_len == 512, "R4", hi_len, 512);
    wr(32'h0); idle(520);

    // R6 enable clear: no activity
    wr(32'h02);
    r0 = rise_cnt;
    idle(40);
    chk(rise_cnt == r0 && card_clk == 1'b0, "R6", rise_cnt - r0, 0);

    // R8 stop request at every offset of a divide-by-8 high phase
    for (int off = 0; off < 4; off++) begin
      wr(32'h02 | EN);
      wait_rises(2);
      f0 = fall_cnt;
      repeat (off) @(posedge clk);
      wr(32'h02);
      wait_fall(f0);
      chk(hi_len == 4, "R8", hi_len, 4);
      r0 = rise_cnt;
      idle(30);
      chk(rise_cnt == r0, "R8", rise_cnt - r0, 0);
    end

    // R7 auto-stop
    wr(32'h02 | EN | AUTO);
    r0 = rise_cnt;
    idle(40);
    chk(rise_cnt == r0, "R7", rise_cnt - r0, 0);
    @(negedge clk); bus_busy = 1'b1;
    wait_rises(2);
    chk(hi_len == 4 && lo_len == 4, "R7", hi_len, 4);
    f0 = fall_cnt;
    repeat (2) @(posedge clk);
    @(negedge clk); bus_busy = 1'b0;
    wait_fall(f0);
    chk(hi_len == 4, "R7", hi_len, 4);
    r0 = rise_cnt;
    idle(30);
    chk(rise_cnt == r0, "R7", rise_cnt - r0, 0);
    @(negedge clk); bus_busy = 1'b1;
    wait_rises(2);
    chk(hi_len == 4 && lo_len == 4, "R7", lo_len, 4);
    @(negedge clk); bus_busy = 1'b0;

    // R9 ratio change while running: 8 -> 32
    wr(32'h02 | EN);
    wait_rises(2);
    min_run = 9999;
    wr(32'h08 | EN);
    wait_rises(3);
    chk(hi_len == 16 && lo_len == 16, "R9", hi_len, 16);
    chk(min_run >= 4, "R9", min_run, 4);

    // R3 pass-through, with bit 16 and a field bit also set
    wr(32'h0); idle(40);
    wr(32'h0001_0408);
    idle(40);
    wr(32'h0001_0408 | EN);
    idle(4);
    err = 0;
    repeat (8) begin
      @(posedge clk); #1; if (card_clk !== 1'b1) err++;
      @(negedge clk); #1; if (card_clk !== 1'b0) err++;
    end
    chk(err == 0, "R3", err, 0);

    // R6 pass-through disabled
    wr(32'h0001_0408);
    idle(3);
    err = 0;
    repeat (8) begin
      @(posedge clk); #1; if (card_clk !== 1'b0) err++;
      @(negedge clk); #1; if (card_clk !== 1'b0) err++;
    end
    chk(err == 0, "R6", err, 0);

    // R11 read-back mask
    wr(32'hFFFF_FFFF);
    #1;
    chk(reg_rdata == 32'h0001_07FF, "R11", reg_rdata, 32'h0001_07FF);
    wr(32'hFFFE_F800);
    #1;
    chk(reg_rdata == 32'h0, "R11", reg_rdata, 0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule